// File: doc/BRIEF.md
# Keyed Two-Stage Watchdog Timer

This block is a watchdog for a slow timebase. A single-cycle `tick` strobe advances it. Software programs it through a small 32-bit register port. A write to a control location takes effect only if the written word carries a code that belongs to that location, so a stray store cannot disarm or reprogram the timer.

Once armed, the timer counts down a programmed number of units, where one unit is `UNIT_TICKS` ticks. Software keeps the system alive by writing the restart code before the count runs out. In single-stage operation, running out of time produces a reset pulse lasting `RST_TICKS` ticks. In two-stage operation, the first expiry raises an interrupt and starts a fresh period, and only a second expiry produces the reset pulse. The reset pulse is also driven onto an external pin whose polarity can be programmed. A separate software command fires the reset pulse at once.

Top module: `kwdt_top`

## Requirements
- R1: A write to offset 0x00 (control) is accepted only when bits 31:24 hold 0x22. Bit 0 is run, bit 1 is pin polarity (1 = active high), bit 2 is pin enable, bit 3 is interrupt enable, bit 4 is auto-rearm and bit 6 is two-stage. A read returns these fields and zero in every other bit. A write with any other key changes nothing.
- R2: A write to offset 0x04 (length) is accepted only when bits 4:0 equal 0x08. Bits 5 upward hold the LEN_W-bit unit count. A read returns the count shifted left by 5 with the key bits at zero. A rejected write changes nothing.
- R3: A reload takes the count back to the full programmed length. Three things cause a reload: an accepted length write, writing 0x1971 to offset 0x08, and an accepted control write that turns run from 0 to 1. Expiry comes after max(length,1)×UNIT_TICKS tick strobes counted from the cycle after the write. The timer advances only on cycles where tick is high and run is 1.
- R4: A write to offset 0x08 with any value other than 0x1971 does not reload the count.
- R5: In single-stage operation, an expiry raises sys_rst_o for RST_TICKS tick strobes, starting in the cycle after the expiring edge.
- R6: When two-stage and interrupt enable are both set, the first expiry raises irq_o and reloads. A second expiry with no restart in between clears irq_o and fires the reset pulse. A restart clears irq_o and returns the timer to the first stage.
- R7: With two-stage set and interrupt enable clear, the first expiry fires the reset pulse and irq_o stays low.
- R8: Clearing run stops the count, returns the timer to the first stage and clears irq_o one cycle after the control register changes.
- R9: After an expiry that fires the reset, run is cleared unless auto-rearm is set. With auto-rearm set, run stays 1 and a new period starts at once.
- R10: Writing 0x1209 to offset 0x14 fires the reset pulse in the next cycle, whether or not the timer runs. Any other value there has no effect.
- R11: With pin enable set, ext_rst_o carries the reset pulse in the programmed polarity. With pin enable clear, it rests at the inactive level: low for active high, high for active low.
- R12: After reset, the control register reads 0, the length reads all ones in its field, and irq_o and sys_rst_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timebase strobe, one cycle wide |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 = write, qualified by bus_sel |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data including the key |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq_o | output | 1 | First-stage expiry interrupt (level) |
| sys_rst_o | output | 1 | System reset pulse, active high |
| ext_rst_o | output | 1 | External reset pin, programmable polarity |

## Verification
The assertions assume that a register write lasts exactly one cycle with bus_sel and bus_wr high together. They also assume that tick is a plain strobe that needs no synchronizing, and that bus_addr is stable while bus_sel is high. The stimulus applies every access through a single write task, which holds the strobes for one clock and drives them only at falling edges. The stimulus holds tick high or low for whole cycles. It spaces restarts and disables so that each lands strictly before the expiry it is meant to prevent.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

    localparam logic [4:0]  OFS_CTRL  = 5'h00;
    localparam logic [4:0]  OFS_LEN   = 5'h04;
    localparam logic [4:0]  OFS_KICK  = 5'h08;
    localparam logic [4:0]  OFS_SWRST = 5'h14;

    localparam logic [7:0]  CTRL_KEY   = 8'h22;
    localparam logic [4:0]  LEN_KEY    = 5'h08;
    localparam logic [31:0] KICK_CODE  = 32'h0000_1971;
    localparam logic [31:0] SWRST_CODE = 32'h0000_1209;

    typedef struct packed {
        logic dual;
        logic auto_go;
        logic irq_en;
        logic ext_en;
        logic ext_hi;
        logic run;
    } ctrl_t;

    typedef enum logic {STG_FIRST, STG_SECOND} stage_e;

    function automatic ctrl_t ctrl_unpack(input logic [31:0] w);
        ctrl_t c;
        c.run     = w[0];
        c.ext_hi  = w[1];
        c.ext_en  = w[2];
        c.irq_en  = w[3];
        c.auto_go = w[4];
        c.dual    = w[6];
        return c;
    endfunction

    function automatic logic [31:0] ctrl_pack(input ctrl_t c);
        logic [31:0] w;
        w    = '0;
        w[0] = c.run;
        w[1] = c.ext_hi;
        w[2] = c.ext_en;
        w[3] = c.irq_en;
        w[4] = c.auto_go;
        w[6] = c.dual;
        return w;
    endfunction

endpackage

// File: rtl/kwdt_regs.sv
module kwdt_regs
    import kwdt_pkg::*;
#(
    parameter int LEN_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_sel_i,
    input  logic             bus_wr_i,
    input  logic [4:0]       bus_addr_i,
    input  logic [31:0]      bus_wdata_i,
    output logic [31:0]      bus_rdata_o,
    input  logic             clr_run_i,
    output ctrl_t            ctrl_o,
    output logic [LEN_W-1:0] len_o,
    output logic             reload_o,
    output logic             swrst_o
);
    ctrl_t            ctrl_q;
    logic [LEN_W-1:0] len_q;
    logic             reload_q;
    logic             wr_go, ctrl_ok, len_ok, kick_ok;
    ctrl_t            ctrl_new;

    assign wr_go    = bus_sel_i && bus_wr_i;
    assign ctrl_new = ctrl_unpack(bus_wdata_i);
    assign ctrl_ok  = wr_go && bus_addr_i == OFS_CTRL && bus_wdata_i[31:24] == CTRL_KEY;
    assign len_ok   = wr_go && bus_addr_i == OFS_LEN  && bus_wdata_i[4:0] == LEN_KEY;
    assign kick_ok  = wr_go && bus_addr_i == OFS_KICK && bus_wdata_i == KICK_CODE;
    assign swrst_o  = wr_go && bus_addr_i == OFS_SWRST && bus_wdata_i == SWRST_CODE;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            len_q    <= '1;
            reload_q <= 1'b0;
        end else begin
            if (ctrl_ok)
                ctrl_q <= ctrl_new;
            else if (clr_run_i)
                ctrl_q.run <= 1'b0;
            if (len_ok)
                len_q <= bus_wdata_i[5 +: LEN_W];
            reload_q <= len_ok || kick_ok || (ctrl_ok && ctrl_new.run && !ctrl_q.run);
        end
    end

    always_comb begin
        case (bus_addr_i)
            OFS_CTRL: bus_rdata_o = ctrl_pack(ctrl_q);
            OFS_LEN:  bus_rdata_o = 32'(len_q) << 5;
            default:  bus_rdata_o = '0;
        endcase
    end

    assign ctrl_o   = ctrl_q;
    assign len_o    = len_q;
    assign reload_o = reload_q;

    // R1: a control write with the wrong key leaves the register alone
    assert_ctrl_key_R1: assert property (@(posedge clk) disable iff (rst)
        (wr_go && bus_addr_i == OFS_CTRL && bus_wdata_i[31:24] != CTRL_KEY && !clr_run_i)
        |=> $stable(ctrl_q));

    // R2: a length write with the wrong key leaves the length alone
    assert_len_key_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_go && bus_addr_i == OFS_LEN && bus_wdata_i[4:0] != LEN_KEY)
        |=> $stable(len_q));

endmodule

// File: rtl/kwdt_timer.sv
module kwdt_timer
    import kwdt_pkg::*;
#(
    parameter int LEN_W      = 11,
    parameter int UNIT_TICKS = 512
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             run_i,
    input  logic             dual_i,
    input  logic             irq_en_i,
    input  logic             auto_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             reload_i,
    output logic             irq_o,
    output logic             fire_o,
    output logic             clr_run_o
);
    localparam int PRE_W = (UNIT_TICKS > 1) ? $clog2(UNIT_TICKS) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(UNIT_TICKS - 1);

    logic [PRE_W-1:0] pre_q;
    logic [LEN_W-1:0] cnt_q;
    stage_e           stage_q;
    logic             irq_q;
    logic             step, wrap, expire, two_stage, bark;

    assign step      = run_i && tick_i && !reload_i;
    assign wrap      = step && pre_q == PRE_LAST;
    assign expire    = wrap && cnt_q <= LEN_W'(1);
    assign two_stage = dual_i && irq_en_i;
    assign bark      = expire && two_stage && stage_q == STG_FIRST;
    assign fire_o    = expire && !bark;
    assign clr_run_o = fire_o && !auto_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q   <= '0;
            cnt_q   <= '1;
            stage_q <= STG_FIRST;
            irq_q   <= 1'b0;
        end else if (reload_i) begin
            pre_q   <= '0;
            cnt_q   <= len_i;
            stage_q <= STG_FIRST;
            irq_q   <= 1'b0;
        end else if (!run_i) begin
            stage_q <= STG_FIRST;
            irq_q   <= 1'b0;
        end else if (step) begin
            if (wrap) begin
                pre_q <= '0;
                if (expire) begin
                    cnt_q   <= len_i;
                    stage_q <= bark ? STG_SECOND : STG_FIRST;
                    irq_q   <= bark;
                end else begin
                    cnt_q <= cnt_q - LEN_W'(1);
                end
            end else begin
                pre_q <= pre_q + PRE_W'(1);
            end
        end
    end

    assign irq_o = irq_q;

    // R6: the interrupt only rises while armed in two-stage mode with it enabled
    assert_irq_cause_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_o) |-> $past(run_i && dual_i && irq_en_i));

    // R8: a stopped timer holds its prescaler and drops the interrupt
    assert_stop_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!run_i && !reload_i) |=> ($stable(pre_q) && !irq_o));

endmodule

// File: rtl/kwdt_rstgen.sv
module kwdt_rstgen #(
    parameter int RST_TICKS = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic fire_i,
    input  logic swrst_i,
    input  logic ext_en_i,
    input  logic ext_hi_i,
    output logic sys_rst_o,
    output logic ext_rst_o
);
    localparam int CW = $clog2(RST_TICKS + 1);

    logic [CW-1:0] left_q;
    logic          pulse;

    always_ff @(posedge clk) begin
        if (rst)
            left_q <= '0;
        else if (fire_i || swrst_i)
            left_q <= CW'(RST_TICKS);
        else if (tick_i && left_q != '0)
            left_q <= left_q - CW'(1);
    end

    assign pulse     = left_q != '0;
    assign sys_rst_o = pulse;
    assign ext_rst_o = ext_en_i ? (ext_hi_i ? pulse : !pulse) : !ext_hi_i;

    // R5: a timer expiry that fires is seen on the reset output next cycle
    assert_fire_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        fire_i |=> sys_rst_o);

endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
    import kwdt_pkg::*;
#(
    parameter int LEN_W      = 11,
    parameter int UNIT_TICKS = 512,
    parameter int RST_TICKS  = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [4:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq_o,
    output logic        sys_rst_o,
    output logic        ext_rst_o
);
    ctrl_t            ctrl;
    logic [LEN_W-1:0] len;
    logic             reload, swrst, fire, clr_run;

    kwdt_regs #(.LEN_W(LEN_W)) u_regs (
        .clk(clk), .rst(rst),
        .bus_sel_i(bus_sel), .bus_wr_i(bus_wr), .bus_addr_i(bus_addr),
        .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
        .clr_run_i(clr_run), .ctrl_o(ctrl), .len_o(len),
        .reload_o(reload), .swrst_o(swrst)
    );

    kwdt_timer #(.LEN_W(LEN_W), .UNIT_TICKS(UNIT_TICKS)) u_timer (
        .clk(clk), .rst(rst), .tick_i(tick),
        .run_i(ctrl.run), .dual_i(ctrl.dual), .irq_en_i(ctrl.irq_en),
        .auto_i(ctrl.auto_go), .len_i(len), .reload_i(reload),
        .irq_o(irq_o), .fire_o(fire), .clr_run_o(clr_run)
    );

    kwdt_rstgen #(.RST_TICKS(RST_TICKS)) u_rstgen (
        .clk(clk), .rst(rst), .tick_i(tick),
        .fire_i(fire), .swrst_i(swrst),
        .ext_en_i(ctrl.ext_en), .ext_hi_i(ctrl.ext_hi),
        .sys_rst_o(sys_rst_o), .ext_rst_o(ext_rst_o)
    );

    // R10: the software reset command reaches the reset output next cycle
    assert_swrst_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        swrst |=> sys_rst_o);

endmodule

// File: tb/test_kwdt_top.sv
module test_kwdt_top;
    import kwdt_pkg::*;

    localparam int U  = 4;
    localparam int RT = 6;
    localparam int L  = 3;
    localparam int LU = L * U;

    localparam logic [1:0] K_IRQ_UP = 2'd0, K_IRQ_DN = 2'd1, K_RST_UP = 2'd2, K_RST_DN = 2'd3;

    typedef struct packed {
        logic [1:0]  kind;
        logic [31:0] at;
        logic        ext;
        logic [3:0]  req;
    } ev_t;

    logic        clk = 1'b0, rst = 1'b1, tick = 1'b1;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, sys_rst_o, ext_rst_o;

    int  cyc = 0, total = 0, bad = 0;
    bit  done = 1'b0;
    ev_t exp_q[$];
    logic irq_prev = 1'b0, rst_prev = 1'b0;

    kwdt_top #(.LEN_W(11), .UNIT_TICKS(U), .RST_TICKS(RT)) i_kwdt_top (
        .clk(clk), .rst(rst), .tick(tick),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .sys_rst_o(sys_rst_o), .ext_rst_o(ext_rst_o)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic string rname(input logic [3:0] r);
        case (r)
            4'd3:  return "R3";
            4'd4:  return "R4";
            4'd5:  return "R5";
            4'd6:  return "R6";
            4'd7:  return "R7";
            4'd8:  return "R8";
            4'd9:  return "R9";
            4'd10: return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic expect_ev(input logic [1:0] k, input int at, input logic ext, input logic [3:0] r);
        ev_t e;
        e.kind = k; e.at = at; e.ext = ext; e.req = r;
        exp_q.push_back(e);
    endtask

    task automatic take_ev(input logic [1:0] k);
        ev_t e;
        total++;
        if (exp_q.size() == 0) begin
            bad++;
            $display("FAIL unexpected edge: actual kind=%0d at=%0d expected none", k, cyc);
        end else begin
            e = exp_q.pop_front();
            if (e.kind != k || e.at != cyc) begin
                bad++;
                $display("FAIL %s: actual kind=%0d at=%0d expected kind=%0d at=%0d",
                         rname(e.req), k, cyc, e.kind, e.at);
            end
            if (k == K_RST_UP) chk(32'(ext_rst_o), 32'(e.ext), "R11 pin during pulse");
        end
    endtask

    // monitor: compares observed output edges with the scoreboard
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (irq_o !== irq_prev)     take_ev(irq_o ? K_IRQ_UP : K_IRQ_DN);
            if (sys_rst_o !== rst_prev) take_ev(sys_rst_o ? K_RST_UP : K_RST_DN);
        end
        irq_prev = irq_o;
        rst_prev = sys_rst_o;
    end

    task automatic wr(input logic [4:0] a, input logic [31:0] d, output int c);
        @(negedge clk);
        c = cyc;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        report();
    end

    initial begin
        int c, c1, cb, x;
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R12 reset state
        rd(OFS_CTRL, v); chk(v, 32'h0, "R12 ctrl reset");
        rd(OFS_LEN, v);  chk(v, 32'h0000_FFE0, "R12 length reset");
        chk(32'(irq_o), 0, "R12 irq low");
        chk(32'(sys_rst_o), 0, "R12 reset low");
        chk(32'(ext_rst_o), 1, "R11 idle pin active-low");

        // R2 length with key, then with bad key
        wr(OFS_LEN, (32'(L) << 5) | 32'h08, c);
        rd(OFS_LEN, v); chk(v, 32'h60, "R2 length accepted");
        wr(OFS_LEN, (32'd5 << 5) | 32'h07, c);
        rd(OFS_LEN, v); chk(v, 32'h60, "R2 bad key ignored");
        // R1 bad control key: must not arm (no edges may follow)
        wr(OFS_CTRL, 32'h2100_0001, c);
        rd(OFS_CTRL, v); chk(v, 32'h0, "R1 bad key ignored");
        repeat (30) @(negedge clk);

        // R5 single stage, pin enabled active high; R9 run cleared afterwards
        wr(OFS_CTRL, 32'h2200_0007, c);
        expect_ev(K_RST_UP, c + 2 + LU, 1'b1, 4'd5);
        expect_ev(K_RST_DN, c + 2 + LU + RT, 1'b0, 4'd5);
        rd(OFS_CTRL, v); chk(v, 32'h07, "R1 ctrl accepted, key reads zero");
        drain();
        rd(OFS_CTRL, v); chk(v, 32'h06, "R9 run cleared without auto-rearm");
        chk(32'(ext_rst_o), 0, "R11 idle pin active-high");

        // R3 restart, R4 bad restart value, R9 auto-rearm, pin active low
        wr(OFS_CTRL, 32'h2200_0015, c);
        repeat (4) @(negedge clk);
        wr(OFS_KICK, KICK_CODE, c1);
        repeat (4) @(negedge clk);
        wr(OFS_KICK, 32'h0000_1970, cb);
        x = c1 + 2 + LU;
        expect_ev(K_RST_UP, x, 1'b0, 4'd4);
        expect_ev(K_RST_DN, x + RT, 1'b0, 4'd3);
        expect_ev(K_RST_UP, x + LU, 1'b0, 4'd9);
        expect_ev(K_RST_DN, x + LU + RT, 1'b0, 4'd9);
        while (cyc < x + LU + 2) @(negedge clk);
        wr(OFS_CTRL, 32'h2200_0014, c);
        drain();
        repeat (30) @(negedge clk);
        rd(OFS_CTRL, v); chk(v, 32'h14, "R8 stopped");

        // R6 two stage: interrupt, then reset
        wr(OFS_CTRL, 32'h2200_0049, c);
        x = c + 2 + LU;
        expect_ev(K_IRQ_UP, x, 1'b0, 4'd6);
        expect_ev(K_IRQ_DN, x + LU, 1'b0, 4'd6);
        expect_ev(K_RST_UP, x + LU, 1'b1, 4'd6);
        expect_ev(K_RST_DN, x + LU + RT, 1'b0, 4'd6);
        drain();
        rd(OFS_CTRL, v); chk(v, 32'h48, "R9 run cleared after two-stage reset");

        // R6 restart between stages; R8 disable clears irq and stops
        wr(OFS_CTRL, 32'h2200_0049, c);
        x = c + 2 + LU;
        expect_ev(K_IRQ_UP, x, 1'b0, 4'd6);
        while (cyc < x + 2) @(negedge clk);
        wr(OFS_KICK, KICK_CODE, c1);
        expect_ev(K_IRQ_DN, c1 + 2, 1'b0, 4'd6);
        expect_ev(K_IRQ_UP, c1 + 2 + LU, 1'b0, 4'd6);
        while (cyc < c1 + 2 + LU + 2) @(negedge clk);
        wr(OFS_CTRL, 32'h2200_0048, c);
        expect_ev(K_IRQ_DN, c + 2, 1'b0, 4'd8);
        drain();
        repeat (40) @(negedge clk);

        // R7 two-stage without interrupt enable acts as single stage
        wr(OFS_CTRL, 32'h2200_0041, c);
        expect_ev(K_RST_UP, c + 2 + LU, 1'b1, 4'd7);
        expect_ev(K_RST_DN, c + 2 + LU + RT, 1'b0, 4'd7);
        drain();

        // R10 software reset: wrong value ignored, right value fires
        wr(OFS_SWRST, 32'h0000_1208, c);
        repeat (10) @(negedge clk);
        wr(OFS_SWRST, SWRST_CODE, c);
        expect_ev(K_RST_UP, c + 1, 1'b1, 4'd10);
        expect_ev(K_RST_DN, c + 1 + RT, 1'b0, 4'd10);
        drain();

        // R3 counting only on tick strobes
        @(negedge clk); tick = 1'b0;
        wr(OFS_CTRL, 32'h2200_0001, c);
        while (cyc < c + 19) @(negedge clk);
        tick = 1'b1;
        expect_ev(K_RST_UP, c + 19 + LU, 1'b1, 4'd3);
        expect_ev(K_RST_DN, c + 19 + LU + RT, 1'b0, 4'd3);
        drain();

        // R11 pin disabled with active-high polarity rests low
        wr(OFS_CTRL, 32'h2200_0002, c);
        @(negedge clk);
        chk(32'(ext_rst_o), 0, "R11 disabled pin active-high idle");

        chk(32'(exp_q.size()), 0, "R3 scoreboard empty");
        report();
    end
endmodule